// File: doc/BRIEF.md
# Damper kick output shaper

This block turns a per-bunch transverse error value into the signed kick word for a push-pull pair of DAC channels. Each accepted sample goes through a sum-signal gate first: if the beam sum is under a programmable threshold, no beam is assumed and the kick is zero. Otherwise one of four transfer functions shapes it: straight linear, linear scaled by a programmable gain, bang-bang, or bang-bang with a deadband. The shaped word then passes through a programmable delay line clocked by the RF clock, so that the kick reaches the bunch it was measured on.

A cycle-time counter starts at each cycle-start pulse. Once it reaches a programmed count, the shaper switches from the first transfer-function selection to a second one and keeps it until the next cycle start. The minus channel always carries the exact negative of the plus channel. Both channels are held to a symmetric range so that negation can never overflow.

The sample input is a valid/ready stream. The block never applies back-pressure: `in_ready` is high whenever reset is released, and every clock with `in_valid` high is taken. The output side has no ready, because the DAC consumes a word on every RF clock. `out_valid` marks the slots that carry an accepted sample, and the words in all other slots are zero.

Top module: `kick_shaper`

## Requirements
- R1: With mode code 0 (linear), the kick equals the error. An error of -512 is clamped to -511.
- R2: With mode code 1 (scaled), the kick is floor(error × gain / 16) saturated to ±511. The gain is 8-bit unsigned with 4 fractional bits.
- R3: With mode code 2 (bang-bang), a positive error gives +511, a negative error gives -511 and zero gives 0.
- R4: With mode code 3 (deadband), an error whose magnitude is at or below `deadband` gives 0. Any other error gives ±511 with the error's sign.
- R5: An accepted sample whose `sum_in` is below `sum_cutoff` gives a kick of 0. A sum equal to the cutoff is not gated. `out_valid` is not affected.
- R6: A sample captured at RF clock edge e appears on the outputs right after edge e+D, where D = `align_dly` in the range 0..31 at the time of observation. D = 0 means one register stage.
- R7: `kick_neg` always equals -`kick_pos`, and neither output ever holds -512.
- R8: Let a sample be accepted n edges after the edge that captured `cycle_start`, with T = `switch_time`. If n ≥ T+2 it is shaped with `mode_b`, otherwise with `mode_a`. Once switched, `mode_b` is held until the next cycle start. Reset counts as a cycle start.
- R9: During and after reset the outputs are 0 and `out_valid` is low. `in_ready` is high after reset. A slot without an accepted sample has `out_valid` low and outputs 0.
- R10: A new `cycle_start` returns the selection to `mode_a` for the samples that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rf_clk | input | 1 | RF clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_start | input | 1 | One-clock pulse at the start of a machine cycle |
| in_valid | input | 1 | Error/sum sample valid |
| in_ready | output | 1 | Sample accepted (high after reset) |
| err_in | input | 10 | Signed per-bunch error |
| sum_in | input | 10 | Unsigned sum sample |
| sum_cutoff | input | 10 | Sum gate threshold |
| mode_a | input | 2 | Transfer function before the switch time |
| mode_b | input | 2 | Transfer function after the switch time |
| switch_time | input | 16 | RF clocks from cycle start to the switch |
| gain | input | 8 | Scaled-mode gain, 4 fractional bits |
| deadband | input | 10 | Deadband magnitude |
| align_dly | input | 5 | Bunch alignment delay in RF clocks |
| kick_pos | output | 10 | Signed plus-channel kick |
| kick_neg | output | 10 | Signed minus-channel kick |
| out_valid | output | 1 | Output slot carries an accepted sample |

## Verification
The bench builds the block with its default parameters: 10-bit words, a 5-bit delay select, an 8-bit gain with 4 fractional bits and a 16-bit cycle counter. With these values every alignment delay from 0 up to the full 31 stages can be exercised, along with the saturation edges of the scaled mode at the largest gains. The switch-time values used are small (0, 5 and a few random ones), so the transfer-function change and its reset at a new cycle start happen many times within a short run. The delay is changed from one clock to the next while data flows, which tests that the tap selection reads a line that keeps shifting regardless of the delay setting.

// File: rtl/kick_pkg.sv
package kick_pkg;
  typedef enum logic [1:0] {
    XF_LINEAR  = 2'd0,
    XF_SCALED  = 2'd1,
    XF_BANG    = 2'd2,
    XF_BANG_DB = 2'd3
  } xfer_e;
endpackage

// File: rtl/kick_xfer.sv
// Sum gate plus the four transfer functions, purely combinational.
module kick_xfer #(
  parameter int W         = 10,
  parameter int SUM_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4
) (
  input  kick_pkg::xfer_e          mode,
  input  logic                     valid,
  input  logic signed [W-1:0]      err,
  input  logic [SUM_W-1:0]         sum,
  input  logic [SUM_W-1:0]         cutoff,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [W-1:0]             deadband,
  output logic signed [W-1:0]      shaped
);
  import kick_pkg::*;

  localparam int PW = W + GAIN_W + 1;
  localparam logic signed [W-1:0]  FULL_P = W'((1 << (W-1)) - 1);
  localparam logic signed [W-1:0]  FULL_N = -FULL_P;
  localparam logic signed [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [PW-1:0] SAT_P = PW'((1 << (W-1)) - 1);
  localparam logic signed [PW-1:0] SAT_N = -SAT_P;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [W-1:0]  lin_v;
  logic signed [W-1:0]  scl_v;
  logic signed [W-1:0]  sgn_v;
  logic [W-1:0]         mag;

  always_comb begin
    prod   = err * $signed({1'b0, gain});
    scaled = prod >>> GAIN_FRAC;
    if (scaled > SAT_P)      scl_v = FULL_P;
    else if (scaled < SAT_N) scl_v = FULL_N;
    else                     scl_v = scaled[W-1:0];

    lin_v = (err == MOST_NEG) ? FULL_N : err;
    mag   = err[W-1] ? W'(-err) : W'(err);

    if (err == '0)      sgn_v = '0;
    else if (err[W-1])  sgn_v = FULL_N;
    else                sgn_v = FULL_P;

    shaped = '0;
    if (valid && sum >= cutoff) begin
      unique case (mode)
        XF_LINEAR:  shaped = lin_v;
        XF_SCALED:  shaped = scl_v;
        XF_BANG:    shaped = sgn_v;
        XF_BANG_DB: shaped = (mag <= deadband) ? '0 : sgn_v;
        default:    shaped = '0;
      endcase
    end
  end
endmodule

// File: rtl/kick_mode_timer.sv
// Counts RF clocks from cycle start and picks the active transfer function.
module kick_mode_timer #(
  parameter int TIME_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [TIME_W-1:0]    switch_time,
  input  kick_pkg::xfer_e      mode_a,
  input  kick_pkg::xfer_e      mode_b,
  output kick_pkg::xfer_e      mode,
  output logic                 second
);
  logic [TIME_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      second <= 1'b0;
    end else if (start) begin
      cnt    <= '0;
      second <= 1'b0;
    end else if (!second) begin
      if (cnt == switch_time) second <= 1'b1;
      else                    cnt    <= cnt + 1'b1;
    end
  end

  assign mode = second ? mode_b : mode_a;

  // R10: a cycle start always returns to the first selection
  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !second);
  // R8: the second selection is held until the next cycle start
  a_r8_hold_second: assert property (@(posedge clk) disable iff (!rst_n)
    second && !start |=> second);
endmodule

// File: rtl/kick_align.sv
// Capture register followed by a tapped shift line for bunch alignment.
module kick_align #(
  parameter int W     = 10,
  parameter int DLY_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [W-1:0] din,
  input  logic                vin,
  input  logic [DLY_W-1:0]    dly,
  output logic signed [W-1:0] dout,
  output logic                vout
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic signed [W-1:0] tap_d [DEPTH+1];
  logic                tap_v [DEPTH+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tap_d[0] <= '0;
      tap_v[0] <= 1'b0;
    end else begin
      tap_d[0] <= din;
      tap_v[0] <= vin;
    end
  end

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tap_d[k] <= '0;
        tap_v[k] <= 1'b0;
      end else begin
        tap_d[k] <= tap_d[k-1];
        tap_v[k] <= tap_v[k-1];
      end
    end
  end

  assign dout = tap_d[dly];
  assign vout = tap_v[dly];

  // R6: with no extra delay a sample shows up after one register stage
  a_r6_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
    vin ##1 (dly == '0) |-> vout);
endmodule

// File: rtl/kick_shaper.sv
module kick_shaper #(
  parameter int W         = 10,
  parameter int SUM_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int DLY_W     = 5,
  parameter int TIME_W    = 16
) (
  input  logic                 rf_clk,
  input  logic                 rst_n,
  input  logic                 cycle_start,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [W-1:0]  err_in,
  input  logic [SUM_W-1:0]     sum_in,
  input  logic [SUM_W-1:0]     sum_cutoff,
  input  logic [1:0]           mode_a,
  input  logic [1:0]           mode_b,
  input  logic [TIME_W-1:0]    switch_time,
  input  logic [GAIN_W-1:0]    gain,
  input  logic [W-1:0]         deadband,
  input  logic [DLY_W-1:0]     align_dly,
  output logic signed [W-1:0]  kick_pos,
  output logic signed [W-1:0]  kick_neg,
  output logic                 out_valid
);
  import kick_pkg::*;

  localparam logic signed [W-1:0] FULL_P   = W'((1 << (W-1)) - 1);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  xfer_e               act_mode;
  logic                second_sel;
  logic                take;
  logic signed [W-1:0] shaped;
  logic signed [W-1:0] aligned;

  always_ff @(posedge rf_clk) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign take = in_valid && in_ready;

  kick_mode_timer #(.TIME_W(TIME_W)) u_timer (
    .clk(rf_clk), .rst_n(rst_n), .start(cycle_start),
    .switch_time(switch_time),
    .mode_a(xfer_e'(mode_a)), .mode_b(xfer_e'(mode_b)),
    .mode(act_mode), .second(second_sel)
  );

  kick_xfer #(.W(W), .SUM_W(SUM_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_xfer (
    .mode(act_mode), .valid(take), .err(err_in), .sum(sum_in),
    .cutoff(sum_cutoff), .gain(gain), .deadband(deadband), .shaped(shaped)
  );

  kick_align #(.W(W), .DLY_W(DLY_W)) u_align (
    .clk(rf_clk), .rst_n(rst_n), .din(shaped), .vin(take),
    .dly(align_dly), .dout(aligned), .vout(out_valid)
  );

  assign kick_pos = aligned;
  assign kick_neg = -aligned;

  // R7: symmetric range on both channels
  a_r7_sym_range: assert property (@(posedge rf_clk) disable iff (!rst_n)
    kick_pos != MOST_NEG && kick_neg != MOST_NEG);
  // R5: gated sample leaves a zero kick at zero delay
  a_r5_cutoff_zero: assert property (@(posedge rf_clk) disable iff (!rst_n)
    take && sum_in < sum_cutoff ##1 align_dly == '0 |-> kick_pos == '0);
  // R3: bang-bang only produces the three levels
  a_r3_bang_levels: assert property (@(posedge rf_clk) disable iff (!rst_n)
    take && act_mode == XF_BANG ##1 align_dly == '0
      |-> (kick_pos == '0 || kick_pos == FULL_P || kick_pos == -FULL_P));
  // R9: empty slots carry zero
  a_r9_idle_zero: assert property (@(posedge rf_clk) disable iff (!rst_n)
    !out_valid |-> kick_pos == '0);
endmodule

// File: tb/sim_kick_shaper.sv
`timescale 1ns/1ps
module sim_kick_shaper;
  logic              rf_clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cycle_start = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic signed [9:0] err_in = '0;
  logic [9:0]        sum_in = '0;
  logic [9:0]        sum_cutoff = '0;
  logic [1:0]        mode_a = '0;
  logic [1:0]        mode_b = '0;
  logic [15:0]       switch_time = 16'd1000;
  logic [7:0]        gain = 8'd16;
  logic [9:0]        deadband = '0;
  logic [4:0]        align_dly = '0;
  logic signed [9:0] kick_pos;
  logic signed [9:0] kick_neg;
  logic              out_valid;

  kick_shaper u0 (
    .rf_clk(rf_clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .in_valid(in_valid), .in_ready(in_ready), .err_in(err_in),
    .sum_in(sum_in), .sum_cutoff(sum_cutoff), .mode_a(mode_a),
    .mode_b(mode_b), .switch_time(switch_time), .gain(gain),
    .deadband(deadband), .align_dly(align_dly), .kick_pos(kick_pos),
    .kick_neg(kick_neg), .out_valid(out_valid)
  );

  always #4 rf_clk = ~rf_clk;

  int total = 0;
  int bad = 0;
  int hist_val [8192];
  bit hist_vld [8192];
  int hist_req [8192];
  int edge_i = 0;
  int start_edge = 0;
  int cur_t = 1000;
  int phase_req = 0;

  task automatic check(int req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_i);
    end
  endtask

  function automatic int shape(int e, int s, int m, int g, int db, int cut, bit v);
    int p;
    if (!v || s < cut) return 0;
    case (m)
      0: return (e < -511) ? -511 : e;
      1: begin
        p = (e * g) >>> 4;
        if (p > 511) p = 511;
        if (p < -511) p = -511;
        return p;
      end
      2: return (e > 0) ? 511 : ((e < 0) ? -511 : 0);
      default: begin
        if ((e < 0 ? -e : e) <= db) return 0;
        return (e > 0) ? 511 : -511;
      end
    endcase
  endfunction

  function automatic int req_of(int m, int s, int cut, bit v);
    if (v && s < cut) return 5;
    return m + 1;
  endfunction

  // One RF clock: drive at the falling edge, capture, then check at the next falling edge.
  task automatic step(int e, int s, bit v, bit cs);
    int m;
    int idx;
    int exp;
    err_in = 10'(e);
    sum_in = 10'(s);
    in_valid = v;
    cycle_start = cs;
    @(posedge rf_clk);
    edge_i++;
    m = (edge_i - start_edge >= cur_t + 2) ? int'(mode_b) : int'(mode_a);
    hist_val[edge_i] = shape(e, s, m, int'(gain), int'(deadband), int'(sum_cutoff), v);
    hist_vld[edge_i] = v;
    hist_req[edge_i] = (phase_req != 0) ? phase_req : req_of(m, s, int'(sum_cutoff), v);
    if (cs) begin
      start_edge = edge_i;
      cur_t = int'(switch_time);
    end
    @(negedge rf_clk);
    idx = edge_i - int'(align_dly);
    exp = (idx >= 1) ? hist_val[idx] : 0;
    // R6 alignment folded into every comparison; R1..R5, R8 named by hist_req
    check((idx >= 1) ? hist_req[idx] : 9, int'(kick_pos), exp);
    check(7, int'(kick_neg), -exp);                       // R7
    check(9, int'(out_valid), (idx >= 1) ? int'(hist_vld[idx]) : 0); // R9
  endtask

  task automatic set_modes(int a, int b);
    mode_a = 2'(a);
    mode_b = 2'(b);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge rf_clk);
    // R9: reset state
    check(9, int'(kick_pos), 0);
    check(9, int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge rf_clk);
    check(9, int'(in_ready), 1);

    // R1 linear corners
    set_modes(0, 0);
    step(-512, 100, 1, 1);
    step(511, 100, 1, 0);
    step(-1, 100, 1, 0);
    step(0, 100, 1, 0);
    step(37, 100, 0, 0);   // R9 idle slot
    // R2 scaled
    set_modes(1, 1);
    gain = 8'd255;
    step(40, 100, 1, 0);
    step(-41, 100, 1, 0);
    step(-512, 100, 1, 0);
    gain = 8'd24;
    step(-3, 100, 1, 0);
    step(300, 100, 1, 0);
    // R3 bang-bang
    set_modes(2, 2);
    step(1, 100, 1, 0);
    step(-1, 100, 1, 0);
    step(0, 100, 1, 0);
    // R4 deadband edges
    set_modes(3, 3);
    deadband = 10'd20;
    step(20, 100, 1, 0);
    step(-20, 100, 1, 0);
    step(21, 100, 1, 0);
    step(-21, 100, 1, 0);
    deadband = 10'd512;
    step(-512, 100, 1, 0);
    // R5 cutoff boundary
    set_modes(0, 0);
    sum_cutoff = 10'd300;
    step(200, 299, 1, 0);
    step(200, 300, 1, 0);
    step(-200, 0, 1, 0);
    sum_cutoff = 10'd0;
    // R6 long and changing delays
    align_dly = 5'd31;
    for (int i = 0; i < 80; i++) step($urandom_range(0, 1023) - 512, 50, 1, 0);
    for (int i = 0; i < 80; i++) begin
      align_dly = 5'($urandom_range(0, 31));
      step($urandom_range(0, 1023) - 512, 50, ($urandom_range(0, 3) != 0), 0);
    end
    align_dly = 5'd0;
    // R8 / R10 mid-cycle switch
    phase_req = 8;
    set_modes(0, 2);
    switch_time = 16'd5;
    for (int r = 0; r < 3; r++) begin
      step(100, 50, 1, 1);   // R10 start returns to mode_a
      for (int i = 0; i < 12; i++) step(-7 - i, 50, 1, 0);
    end
    switch_time = 16'd0;
    step(5, 50, 1, 1);
    for (int i = 0; i < 5; i++) step(9, 50, 1, 0);
    phase_req = 0;

    // Constrained random across everything
    for (int i = 0; i < 2500; i++) begin
      bit cs;
      cs = ($urandom_range(0, 40) == 0);
      if (cs) switch_time = 16'($urandom_range(0, 30));
      if ($urandom_range(0, 20) == 0) set_modes($urandom_range(0, 3), $urandom_range(0, 3));
      if ($urandom_range(0, 30) == 0) gain = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 30) == 0) deadband = 10'($urandom_range(0, 300));
      if ($urandom_range(0, 30) == 0) sum_cutoff = 10'($urandom_range(0, 200));
      if ($urandom_range(0, 10) == 0) align_dly = 5'($urandom_range(0, 31));
      step($urandom_range(0, 1023) - 512, $urandom_range(0, 1023),
           ($urandom_range(0, 5) != 0), cs);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule